// File: doc/BRIEF.md
# GPIO Pin Bank with Register Interface

This block groups up to 32 general-purpose pins behind a flat 32-bit register bus (byte address, write enable, write data, combinational read data). Each pin is set by software either to ordinary I/O or to interrupt-input duty. In ordinary I/O it is an input or an output. A driven pin takes its value from an output data register or, in the richer variant, from an alternate data source chosen per pin. Pad levels come in through a two-stage synchronizer.

The interrupt-input configuration bits are held here and driven out to a neighbouring interrupt block: the mode bit, polarity, edge or level choice, both-edge choice and filter enable. That block does all edge and level detection. Reading the input-data offset returns a consistent per-pin view. For a pin this block drives, it returns the driven level. For any other pin, it returns the synchronized pad level.

Top module: `gpio_bank`

## Requirements
- R1: After rst_ni is asserted, every register reads 0, pad_oe_o is 0, pad_o is 0, and all configuration outputs are 0.
- R2: A write with we_i high stores wdata_i (masked to the implemented lines) in the register at that offset by the next rising edge. Offsets: 0x00 mode (1 = interrupt input, 0 = ordinary I/O), 0x04 direction (1 = output), 0x08 output data, 0x20 polarity (0 = positive logic), 0x24 edge/level select, 0x28 filter enable, 0x40 output source select, 0x4C both-edge select. Reading the same offset returns the stored value in the same cycle.
- R3: pad_oe_o bit n is 1 exactly when mode bit n is 0 and direction bit n is 1.
- R4: pad_o bit n is the output data bit when output source select bit n is 0, and alt_i bit n when it is 1.
- R5: Reading offset 0x0C returns pad_o for each bit whose pad_oe_o is 1. For every other bit it returns pad_i delayed by two rising edges.
- R6: Reads of any other offset, including misaligned ones, return 0. Writes to such offsets change no register.
- R7: With RICH = 0, the source-select and both-edge registers read 0 and ignore writes, and pad_o always follows the output data register.
- R8: Bits at or above the effective line count read 0 and drive 0 on every output. A NUM_LINES value outside 1..32 behaves as 32.
- R9: mode_o, pol_o, edge_o, both_o and filt_o present the stored mode, polarity, edge/level, both-edge and filter registers.
- R10: The output data register keeps its value across direction and mode changes. It changes only on a write to offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte offset of the access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pad_i | input | 32 | Pad input levels, asynchronous |
| alt_i | input | 32 | Alternate output data per pin |
| pad_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad output enables |
| mode_o | output | 32 | Interrupt-input mode bits to the interrupt block |
| pol_o | output | 32 | Polarity bits |
| edge_o | output | 32 | Edge/level select bits |
| both_o | output | 32 | Both-edge select bits |
| filt_o | output | 32 | Filter enable bits |

## Verification
A register write and a read of the input-data offset can fall in the same cycle as a pad transition. The pad change reaches the read view only after two edges, while a direction or source write switches the read view of a pin at the next edge. The bench exercises both cases: it flips pads while writing direction and source registers, and it issues back-to-back writes with reads between them. A behavioural model with its own synchronizer history is compared against every output on every clock. A default instance, an eight-line lite instance and an instance with an out-of-range line count all receive the same bus traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W    = 32;
  localparam int MAX_LINES = 32;

  localparam int OFF_MODE = 'h00;
  localparam int OFF_DIR  = 'h04;
  localparam int OFF_OUT  = 'h08;
  localparam int OFF_IN   = 'h0C;
  localparam int OFF_POL  = 'h20;
  localparam int OFF_EDGE = 'h24;
  localparam int OFF_FILT = 'h28;
  localparam int OFF_SRC  = 'h40;
  localparam int OFF_BOTH = 'h4C;

  function automatic int eff_lines(int n);
    return (n < 1 || n > MAX_LINES) ? MAX_LINES : n;
  endfunction

  function automatic logic [DATA_W-1:0] line_mask(int n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 32,
  parameter bit RICH   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] in_view_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] dir_o,
  output logic [DATA_W-1:0] out_o,
  output logic [DATA_W-1:0] pol_o,
  output logic [DATA_W-1:0] edge_o,
  output logic [DATA_W-1:0] filt_o,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] both_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] MASK = line_mask(LINES);

  logic [DATA_W-1:0] mode_q, dir_q, out_q, pol_q, edge_q, filt_q, src_q, both_q;
  logic [DATA_W-1:0] wmask;

  assign wmask = wdata_i & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      filt_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(OFF_MODE): mode_q <= wmask;
        ADDR_W'(OFF_DIR):  dir_q  <= wmask;
        ADDR_W'(OFF_OUT):  out_q  <= wmask;
        ADDR_W'(OFF_POL):  pol_q  <= wmask;
        ADDR_W'(OFF_EDGE): edge_q <= wmask;
        ADDR_W'(OFF_FILT): filt_q <= wmask;
        default: ;
      endcase
    end
  end

  generate
    if (RICH) begin : g_rich
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          src_q  <= '0;
          both_q <= '0;
        end else if (we_i) begin
          if (addr_i == ADDR_W'(OFF_SRC))  src_q  <= wmask;
          if (addr_i == ADDR_W'(OFF_BOTH)) both_q <= wmask;
        end
      end
    end else begin : g_lite
      assign src_q  = '0;
      assign both_q = '0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_MODE): rdata_o = mode_q;
      ADDR_W'(OFF_DIR):  rdata_o = dir_q;
      ADDR_W'(OFF_OUT):  rdata_o = out_q;
      ADDR_W'(OFF_IN):   rdata_o = in_view_i;
      ADDR_W'(OFF_POL):  rdata_o = pol_q;
      ADDR_W'(OFF_EDGE): rdata_o = edge_q;
      ADDR_W'(OFF_FILT): rdata_o = filt_q;
      ADDR_W'(OFF_SRC):  rdata_o = src_q;
      ADDR_W'(OFF_BOTH): rdata_o = both_q;
      default:           rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign filt_o = filt_q;
  assign src_o  = src_q;
  assign both_o = both_q;
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_pinmux.sv
module gpio_bank_pinmux
  import gpio_bank_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic [DATA_W-1:0] mode_i,
  input  logic [DATA_W-1:0] dir_i,
  input  logic [DATA_W-1:0] out_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] alt_i,
  input  logic [DATA_W-1:0] sync_i,
  output logic [DATA_W-1:0] pad_o,
  output logic [DATA_W-1:0] pad_oe_o,
  output logic [DATA_W-1:0] in_view_o
);
  localparam logic [DATA_W-1:0] MASK = line_mask(LINES);

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_pin
      if (MASK[i]) begin : g_on
        assign pad_o[i]     = src_i[i] ? alt_i[i] : out_i[i];
        assign pad_oe_o[i]  = ~mode_i[i] & dir_i[i];
        // driven pins read back what is driven; pad level is not trusted
        assign in_view_o[i] = pad_oe_o[i] ? pad_o[i] : sync_i[i];
      end else begin : g_off
        assign pad_o[i]     = 1'b0;
        assign pad_oe_o[i]  = 1'b0;
        assign in_view_o[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 32,
  parameter bit RICH      = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       pad_i,
  input  logic [31:0]       alt_i,
  output logic [31:0]       pad_o,
  output logic [31:0]       pad_oe_o,
  output logic [31:0]       mode_o,
  output logic [31:0]       pol_o,
  output logic [31:0]       edge_o,
  output logic [31:0]       both_o,
  output logic [31:0]       filt_o
);
  localparam int LINES_EFF = eff_lines(NUM_LINES);
  localparam logic [DATA_W-1:0] MASK = line_mask(LINES_EFF);

  logic [DATA_W-1:0] dir_q, out_q, src_q, sync_q, in_view;

  gpio_bank_regs #(.ADDR_W(ADDR_W), .LINES(LINES_EFF), .RICH(RICH)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .in_view_i(in_view),
    .mode_o, .dir_o(dir_q), .out_o(out_q), .pol_o, .edge_o, .filt_o,
    .src_o(src_q), .both_o, .rdata_o
  );

  gpio_bank_sync #(.W(DATA_W), .STAGES(2)) u_sync (
    .clk_i, .rst_ni,
    .d_i(pad_i & MASK),
    .q_o(sync_q)
  );

  gpio_bank_pinmux #(.LINES(LINES_EFF)) u_pinmux (
    .mode_i(mode_o), .dir_i(dir_q), .out_i(out_q), .src_i(src_q),
    .alt_i, .sync_i(sync_q),
    .pad_o, .pad_oe_o, .in_view_o(in_view)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 32,
  parameter bit RICH   = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [31:0]       pad_o,
  input logic [31:0]       pad_oe_o,
  input logic [31:0]       mode_o,
  input logic [31:0]       out_q
);
  localparam logic [31:0] MASK = line_mask(LINES);

  logic mapped;
  always_comb begin
    mapped = (addr_i == ADDR_W'(OFF_MODE)) || (addr_i == ADDR_W'(OFF_DIR)) ||
             (addr_i == ADDR_W'(OFF_OUT))  || (addr_i == ADDR_W'(OFF_IN))  ||
             (addr_i == ADDR_W'(OFF_POL))  || (addr_i == ADDR_W'(OFF_EDGE)) ||
             (addr_i == ADDR_W'(OFF_FILT)) ||
             (RICH && ((addr_i == ADDR_W'(OFF_SRC)) || (addr_i == ADDR_W'(OFF_BOTH))));
  end

  AST_OE_ONLY_IN_GPIO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & mode_o) == 32'h0); // R3

  AST_MODE_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_MODE)) |=> mode_o == ($past(wdata_i) & MASK)); // R2

  AST_OUT_DATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(OFF_OUT)) |=> $stable(out_q)); // R10

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == 32'h0); // R6

  AST_IN_VIEW_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_IN)) |-> ((rdata_o ^ pad_o) & pad_oe_o) == 32'h0); // R5

  AST_LINE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_o | mode_o | rdata_o) & ~MASK) == 32'h0); // R8
endmodule

bind gpio_bank gpio_bank_chk #(.ADDR_W(ADDR_W), .LINES(LINES_EFF), .RICH(RICH)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
  .pad_o, .pad_oe_o, .mode_o, .out_q(out_q)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, pad = '0, alt = '0;
  logic [2:0][31:0] rd_w, po_w, oe_w, md_w, pl_w, ed_w, bt_w, fl_w;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_LINES(32), .RICH(1'b1)) uut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rd_w[0]),
    .pad_i(pad), .alt_i(alt), .pad_o(po_w[0]), .pad_oe_o(oe_w[0]), .mode_o(md_w[0]),
    .pol_o(pl_w[0]), .edge_o(ed_w[0]), .both_o(bt_w[0]), .filt_o(fl_w[0]));
  gpio_bank #(.NUM_LINES(8), .RICH(1'b0)) uut_lite (
    .clk_i(clk), .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rd_w[1]),
    .pad_i(pad), .alt_i(alt), .pad_o(po_w[1]), .pad_oe_o(oe_w[1]), .mode_o(md_w[1]),
    .pol_o(pl_w[1]), .edge_o(ed_w[1]), .both_o(bt_w[1]), .filt_o(fl_w[1]));
  gpio_bank #(.NUM_LINES(40), .RICH(1'b1)) uut_wide (
    .clk_i(clk), .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rd_w[2]),
    .pad_i(pad), .alt_i(alt), .pad_o(po_w[2]), .pad_oe_o(oe_w[2]), .mode_o(md_w[2]),
    .pol_o(pl_w[2]), .edge_o(ed_w[2]), .both_o(bt_w[2]), .filt_o(fl_w[2]));

  // behavioural reference
  logic [31:0] mk [3] = '{32'hFFFF_FFFF, 32'h0000_00FF, 32'hFFFF_FFFF};
  bit          rich [3] = '{1'b1, 1'b0, 1'b1};
  logic [31:0] m_mode[3], m_dir[3], m_out[3], m_pol[3], m_edge[3], m_filt[3], m_src[3], m_both[3];
  logic [31:0] hist[3][$];

  function automatic logic [31:0] m_po(int k);
    return mk[k] & ((m_src[k] & alt) | (~m_src[k] & m_out[k]));
  endfunction
  function automatic logic [31:0] m_oe(int k);
    return mk[k] & ~m_mode[k] & m_dir[k];
  endfunction
  function automatic logic [31:0] m_rd(int k, logic [7:0] a);
    case (a)
      8'h00: return m_mode[k];
      8'h04: return m_dir[k];
      8'h08: return m_out[k];
      8'h0C: return (m_oe(k) & m_po(k)) | (~m_oe(k) & hist[k][0]);
      8'h20: return m_pol[k];
      8'h24: return m_edge[k];
      8'h28: return m_filt[k];
      8'h40: return m_src[k];
      8'h4C: return m_both[k];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_ni) begin
        m_mode[k] <= '0; m_dir[k] <= '0; m_out[k] <= '0; m_pol[k] <= '0;
        m_edge[k] <= '0; m_filt[k] <= '0; m_src[k] <= '0; m_both[k] <= '0;
        hist[k] = '{32'h0, 32'h0};
      end else begin
        if (we) begin
          case (addr)
            8'h00: m_mode[k] <= wdata & mk[k];
            8'h04: m_dir[k]  <= wdata & mk[k];
            8'h08: m_out[k]  <= wdata & mk[k];
            8'h20: m_pol[k]  <= wdata & mk[k];
            8'h24: m_edge[k] <= wdata & mk[k];
            8'h28: m_filt[k] <= wdata & mk[k];
            8'h40: if (rich[k]) m_src[k]  <= wdata & mk[k];
            8'h4C: if (rich[k]) m_both[k] <= wdata & mk[k];
            default: ;
          endcase
        end
        hist[k].push_back(pad & mk[k]);
        void'(hist[k].pop_front());
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  // model compare on every clock, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    for (int k = 0; k < 3; k++) begin
      chk($sformatf("R2 rdata inst%0d", k), rd_w[k], m_rd(k, addr));
      chk($sformatf("R4 pad_o inst%0d", k), po_w[k], m_po(k));
      chk($sformatf("R3 pad_oe inst%0d", k), oe_w[k], m_oe(k));
      chk($sformatf("R9 mode inst%0d", k), md_w[k], m_mode[k]);
      chk($sformatf("R9 pol inst%0d", k), pl_w[k], m_pol[k]);
      chk($sformatf("R9 edge inst%0d", k), ed_w[k], m_edge[k]);
      chk($sformatf("R9 both inst%0d", k), bt_w[k], m_both[k]);
      chk($sformatf("R9 filt inst%0d", k), fl_w[k], m_filt[k]);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, int k, logic [31:0] exp, string tag);
    @(negedge clk); addr = a; we = 1'b0;
    #1 chk(tag, rd_w[k], exp);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pad_oe in reset", oe_w[0], 32'h0);
    chk("R1 pad_o in reset", po_w[0], 32'h0);
    rst_ni = 1'b1;
    foreach (mk[i]) ;
    rd(8'h00, 0, 32'h0, "R1 mode after reset");
    rd(8'h08, 0, 32'h0, "R1 out after reset");
    rd(8'h40, 0, 32'h0, "R1 src after reset");

    // R2/R3: configure modes and direction
    wr(8'h00, 32'h0F00_0000);
    wr(8'h04, 32'hFFFF_0000);
    wr(8'h08, 32'hA5A5_5A5A);
    rd(8'h04, 0, 32'hFFFF_0000, "R2 dir readback");
    chk("R3 oe from mode and dir", oe_w[0], 32'hF0FF_0000);
    chk("R4 pad_o from out data", po_w[0], 32'hA5A5_5A5A);
    chk("R8 lite pad_o masked", po_w[1], 32'h0000_005A);
    chk("R8 lite oe masked", oe_w[1], 32'h0);

    // R5: input view and sync latency
    @(negedge clk); pad = 32'h1234_5678; addr = 8'h0C;
    #1 chk("R5 in view before edges", rd_w[0], 32'hA0A5_0000);
    @(negedge clk); #1 chk("R5 in view after one edge", rd_w[0], 32'hA0A5_0000);
    @(negedge clk); #1 chk("R5 in view after two edges", rd_w[0], 32'hA2A5_5678);
    chk("R8 lite in view masked", rd_w[1], 32'h0000_0078);

    // R4: alternate source; same-cycle pad change
    alt = 32'h0000_0F0F;
    @(negedge clk); pad = 32'h0;
    wr(8'h40, 32'h0000_00FF);
    chk("R4 alternate source", po_w[0], 32'hA5A5_5A0F);
    chk("R7 lite ignores source select", po_w[1], 32'h0000_005A);
    rd(8'h40, 1, 32'h0, "R7 lite source reads 0");

    // R10: output data survives direction changes
    wr(8'h04, 32'h0);
    chk("R10 oe dropped", oe_w[0], 32'h0);
    rd(8'h08, 0, 32'hA5A5_5A5A, "R10 out held while input");
    wr(8'h04, 32'hFFFF_0000);
    wr(8'h00, 32'h0);
    rd(8'h08, 0, 32'hA5A5_5A5A, "R10 out held after mode change");

    // R9: configuration outputs
    wr(8'h20, 32'h0000_0003);
    wr(8'h24, 32'h0000_000C);
    wr(8'h28, 32'h0000_0030);
    wr(8'h4C, 32'h0000_0100);
    chk("R9 pol out", pl_w[0], 32'h3);
    chk("R9 edge out", ed_w[0], 32'hC);
    chk("R9 filt out", fl_w[0], 32'h30);
    chk("R9 both out", bt_w[0], 32'h100);
    chk("R7 lite both out", bt_w[1], 32'h0);

    // R6: unmapped offsets
    foreach (mk[i]) ;
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h10, 0, 32'h0, "R6 unmapped read 0x10");
    rd(8'h01, 0, 32'h0, "R6 misaligned read");
    rd(8'h00, 0, 32'h0, "R6 mode untouched");
    rd(8'h08, 0, 32'hA5A5_5A5A, "R6 out untouched");

    // R8: line-count masking and fallback
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 1, 32'h0000_00FF, "R8 lite mode masked");
    rd(8'h00, 2, 32'hFFFF_FFFF, "R8 out-of-range count uses 32");
    chk("R3 interrupt mode drops oe", oe_w[0], 32'h0);

    // pads toggling during writes
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); pad = pad ^ (32'h1 << n) ^ 32'h8000_0001;
      wr(8'h04, 32'h5555_0000 ^ (n << 4));
      wr(8'h00, 32'h0000_0000);
      rd(8'h0C, 0, m_rd(0, 8'h0C), "R5 in view under traffic");
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule